// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Addressed Registers

This block gathers up to 32 interrupt request lines into a single processor interrupt. Each line is fixed at build time as either level-sensitive or rising-edge-captured. Every line passes through a two-flop synchronizer. While hardware capture is switched on, requests are latched into a sticky status register. An enable register masks the status register to form the pending set. The lowest-numbered pending line is reported as a vector number.

Software reaches the block through a simple single-cycle port. Each access gives valid, write, byte address and write data. Read data comes back from a register one clock later.

Three write-only addresses change bits atomically: one acknowledges status bits, one sets enable bits and one clears enable bits. A two-bit master register has two separate jobs. One bit gates the processor output. The other bit turns hardware capture on. Software may load the status register directly only while capture is off, which lets it inject or clear requests during bring-up.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, status, enable and master registers are zero, the vector reads 0xFFFFFFFF and `cpu_irq` is low.
- R2: Registers sit at byte offsets 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector and 0x1C master. Acknowledge, set-enable and clear-enable read as zero. Writes to pending and vector have no effect. An address at or above 0x20, or with its two low bits nonzero, reads zero and ignores writes.
- R3: The master register keeps only bits [1:0] of a write. Bit 0 gates the processor output and bit 1 turns on hardware capture.
- R4: A write to status replaces it when master bit 1 is 0, and is ignored when master bit 1 is 1.
- R5: A write to acknowledge clears each status bit whose written bit is 1.
- R6: A write to set-enable ORs the data into enable. A write to clear-enable clears the enable bits where the data is 1. A write to enable replaces it.
- R7: Pending reads as status AND enable.
- R8: The vector reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R9: `cpu_irq` is high exactly when master bit 0 is 1 and pending is nonzero.
- R10: A level-sensitive line (kind bit 0) sets its status bit on every clock in which capture is on and its synchronized input is high. A capture and an acknowledge that hit the same bit in the same cycle leave the bit set.
- R11: An edge line (kind bit 1) sets its status bit only on a synchronized rising edge that occurs while capture is on. A line held high after acknowledge does not set the bit again, and an edge that occurs while capture is off is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Asynchronous interrupt request lines |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is an acknowledge and a hardware capture landing on the same bit in the same clock. The bench sets this up by holding a level line high with capture on and then issuing an acknowledge of that bit. Reading status afterwards shows whether the capture won. Edge lines are driven through a full sequence: rise, acknowledge while the line is still held high, a rise while capture is off, and a rise after capture is turned back on. Together these separate a true edge capture from a level capture. A sweep of a single status bit and a single enable bit across all 32 positions checks the vector against every index.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int DATA_W = 32;
    localparam int NUM_REGS = 8;

    // Word index of each register: address bits [4:2]
    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,
        SEL_PEND = 3'd1,
        SEL_ENA  = 3'd2,
        SEL_ACK  = 3'd3,
        SEL_SETE = 3'd4,
        SEL_CLRE = 3'd5,
        SEL_VEC  = 3'd6,
        SEL_MSTR = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic stat_wr;
        logic ena_wr;
        logic ack_wr;
        logic set_wr;
        logic clr_wr;
        logic mstr_wr;
    } wr_strobe_t;

    typedef struct packed {
        logic cap_en;   // bit 1
        logic irq_en;   // bit 0
    } master_t;

    function automatic wr_strobe_t decode_write(input logic hit, input reg_sel_e sel);
        wr_strobe_t s;
        s = '0;
        if (hit) begin
            case (sel)
                SEL_STAT: s.stat_wr = 1'b1;
                SEL_ENA:  s.ena_wr  = 1'b1;
                SEL_ACK:  s.ack_wr  = 1'b1;
                SEL_SETE: s.set_wr  = 1'b1;
                SEL_CLRE: s.clr_wr  = 1'b1;
                SEL_MSTR: s.mstr_wr = 1'b1;
                default:  s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqv_input_stage.sv
module irqv_input_stage #(
    parameter int N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    output logic [N_SRC-1:0] sync_lvl,
    output logic [N_SRC-1:0] cap_req
);

    logic [N_SRC-1:0] meta_q;
    logic [N_SRC-1:0] sync_q;
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= irq_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_lvl = sync_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (KIND[i]) begin : g_edge
            assign cap_req[i] = sync_q[i] & ~prev_q[i];
        end else begin : g_level
            assign cap_req[i] = sync_q[i];
        end
    end

endmodule

// File: rtl/irqv_status_bank.sv
module irqv_status_bank
    import irqv_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       stb,
    input  logic [N_SRC-1:0] wdata,
    input  logic [1:0]       wdata_mstr,
    input  logic [N_SRC-1:0] cap_req,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] enable,
    output master_t          master
);

    logic [N_SRC-1:0] status_n;
    logic [N_SRC-1:0] enable_n;

    always_comb begin
        status_n = status;
        if (stb.stat_wr && !master.cap_en) begin
            status_n = wdata;
        end else begin
            if (stb.ack_wr) status_n = status_n & ~wdata;
            // capture is applied last so it wins over a same-cycle acknowledge
            if (master.cap_en) status_n = status_n | cap_req;
        end
    end

    always_comb begin
        enable_n = enable;
        if (stb.ena_wr)      enable_n = wdata;
        else if (stb.set_wr) enable_n = enable | wdata;
        else if (stb.clr_wr) enable_n = enable & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            master <= '0;
        end else begin
            status <= status_n;
            enable <= enable_n;
            if (stb.mstr_wr) master <= master_t'(wdata_mstr);
        end
    end

endmodule

// File: rtl/irqv_lowest.sv
module irqv_lowest #(
    parameter int N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND = '0,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cpu_irq
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int MAP_BYTES = NUM_REGS * 4;

    logic [N_SRC-1:0] sync_lvl;
    logic [N_SRC-1:0] cap_req;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] enable;
    logic [N_SRC-1:0] pend;
    master_t          master;
    logic             found;
    logic [IDX_W-1:0] vec_idx;
    logic             addr_hit;
    reg_sel_e         sel;
    wr_strobe_t       stb;
    logic [31:0]      rd_mux;

    assign addr_hit = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) < MAP_BYTES);
    assign sel      = reg_sel_e'(bus_addr[4:2]);
    assign stb      = decode_write(bus_valid && bus_write && addr_hit, sel);

    irqv_input_stage #(.N_SRC(N_SRC), .KIND(KIND)) u_in (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .sync_lvl (sync_lvl),
        .cap_req  (cap_req)
    );

    irqv_status_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .wdata      (bus_wdata[N_SRC-1:0]),
        .wdata_mstr (bus_wdata[1:0]),
        .cap_req    (cap_req),
        .status     (status),
        .enable     (enable),
        .master     (master)
    );

    assign pend = status & enable;

    irqv_lowest #(.N_SRC(N_SRC)) u_low (
        .pend  (pend),
        .found (found),
        .idx   (vec_idx)
    );

    assign cpu_irq = master.irq_en & found;

    always_comb begin
        rd_mux = '0;
        if (addr_hit) begin
            case (sel)
                SEL_STAT: rd_mux = 32'(status);
                SEL_PEND: rd_mux = 32'(pend);
                SEL_ENA:  rd_mux = 32'(enable);
                SEL_VEC:  rd_mux = found ? 32'(vec_idx) : 32'hFFFF_FFFF;
                SEL_MSTR: rd_mux = {30'd0, master};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND = '0,
    parameter int ADDR_W = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N_SRC-1:0]  status,
    input logic [N_SRC-1:0]  enable,
    input logic [1:0]        master,
    input logic [N_SRC-1:0]  sync_lvl,
    input logic [N_SRC-1:0]  pend,
    input logic              found,
    input logic [IDX_W-1:0]  vec_idx,
    input logic              cpu_irq
);

    logic wr_any;
    logic [N_SRC-1:0] lvl_hi;
    logic [N_SRC-1:0] below_mask;

    assign wr_any     = bus_valid && bus_write;
    assign lvl_hi     = sync_lvl & ~KIND;
    assign below_mask = (N_SRC'(1) << vec_idx) - N_SRC'(1);

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (master[0] && ((status & enable) != '0)));   // R9

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
        found |-> (pend[vec_idx] && ((pend & below_mask) == '0)));   // R8

    AST_VEC_NONE: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !found);   // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == ADDR_W'(8'h0C) && !master[1])
        |=> ((status & $past(bus_wdata[N_SRC-1:0])) == '0));   // R5

    AST_SET_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == ADDR_W'(8'h10))
        |=> ((enable & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));   // R6

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == '0 && master[1])
        |=> ((~status & $past(status)) == '0));   // R4

    AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (master[1] && lvl_hi != '0)
        |=> ((status & $past(lvl_hi)) == $past(lvl_hi)));   // R10

endmodule

bind irqv_ctrl irqv_checker #(.N_SRC(N_SRC), .KIND(KIND), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .enable    (enable),
    .master    (master),
    .sync_lvl  (sync_lvl),
    .pend      (pend),
    .found     (found),
    .vec_idx   (vec_idx),
    .cpu_irq   (cpu_irq)
);

// File: tb/irqv_ctrl_tb_top.sv
module irqv_ctrl_tb_top;

    localparam int N = 32;
    localparam logic [N-1:0] KIND = 32'hFFFF_0000;  // 0..15 level, 16..31 edge

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    irqv_ctrl #(.N_SRC(N), .KIND(KIND), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1 status", 8'h00, 32'h0);
        rd_chk("R1 pending", 8'h04, 32'h0);
        rd_chk("R1 enable", 8'h08, 32'h0);
        rd_chk("R1 vector", 8'h18, 32'hFFFF_FFFF);
        rd_chk("R1 master", 8'h1C, 32'h0);
        chk("R1 cpu_irq", 32'(cpu_irq), 32'h0);

        // R3: master keeps two bits
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R3 master mask", 8'h1C, 32'h3);
        wr(8'h1C, 32'h0);

        // R2: out of range, misaligned, write-only and read-only
        wr(8'h20, 32'h5555_5555);
        rd_chk("R2 out of range", 8'h20, 32'h0);
        wr(8'h09, 32'hFFFF);
        rd_chk("R2 misaligned write", 8'h08, 32'h0);
        rd_chk("R2 misaligned read", 8'h0A, 32'h0);

        // R6: enable updates
        wr(8'h08, 32'h0000_00F0);
        rd_chk("R6 enable write", 8'h08, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0F00);
        rd_chk("R6 set-enable", 8'h08, 32'h0000_0FF0);
        wr(8'h14, 32'h0000_0330);
        rd_chk("R6 clear-enable", 8'h08, 32'h0000_0CC0);
        rd_chk("R2 ack reads zero", 8'h0C, 32'h0);
        rd_chk("R2 set-enable reads zero", 8'h10, 32'h0);
        rd_chk("R2 clear-enable reads zero", 8'h14, 32'h0);

        // R4/R7: direct status write with capture off
        wr(8'h00, 32'h0000_0A50);
        rd_chk("R4 status write", 8'h00, 32'h0000_0A50);
        rd_chk("R7 pending", 8'h04, 32'h0000_0840);
        wr(8'h04, 32'h1234_5678);
        wr(8'h18, 32'h0000_0005);
        rd_chk("R2 pending write ignored", 8'h04, 32'h0000_0840);
        rd_chk("R2 vector write ignored", 8'h18, 32'd6);

        // R8/R7: sweep vector over all positions
        wr(8'h08, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'hFFFF_FFFF << i);
            rd_chk($sformatf("R8 vector status sweep %0d", i), 8'h18, i);
        end
        wr(8'h00, 32'hFFFF_FFFF);
        for (int j = 0; j < N; j++) begin
            wr(8'h08, 32'h1 << j);
            rd_chk($sformatf("R7 pending enable sweep %0d", j), 8'h04, 32'h1 << j);
            rd_chk($sformatf("R8 vector enable sweep %0d", j), 8'h18, j);
        end
        wr(8'h08, 32'h0);
        rd_chk("R8 none pending", 8'h18, 32'hFFFF_FFFF);

        // R9: processor output gating
        wr(8'h00, 32'h0000_0100);
        wr(8'h08, 32'h0000_0100);
        chk("R9 master off", 32'(cpu_irq), 32'h0);
        wr(8'h1C, 32'h1);
        chk("R9 master on", 32'(cpu_irq), 32'h1);
        wr(8'h14, 32'h0000_0100);
        chk("R9 nothing pending", 32'(cpu_irq), 32'h0);
        wr(8'h10, 32'h0000_0100);
        chk("R9 re-enabled", 32'(cpu_irq), 32'h1);
        wr(8'h1C, 32'h0);
        chk("R9 master cleared", 32'(cpu_irq), 32'h0);

        // R5: acknowledge
        wr(8'h00, 32'h0000_F0F0);
        wr(8'h0C, 32'h0000_30F0);
        rd_chk("R5 ack", 8'h00, 32'h0000_C000);
        wr(8'h00, 32'h0);

        // R4: status write ignored with capture on
        wr(8'h1C, 32'h2);
        wr(8'h00, 32'h0000_AAAA);
        rd_chk("R4 status write ignored", 8'h00, 32'h0);

        // R10: level lines, capture wins over acknowledge
        for (int k = 0; k < 16; k++) begin
            irq_in = 32'h1 << k;
            idle(4);
            rd_chk($sformatf("R10 level capture %0d", k), 8'h00, 32'h1 << k);
            wr(8'h0C, 32'h1 << k);
            rd_chk($sformatf("R10 ack while high %0d", k), 8'h00, 32'h1 << k);
            irq_in = '0;
            idle(4);
            wr(8'h0C, 32'h1 << k);
            rd_chk($sformatf("R10 ack after drop %0d", k), 8'h00, 32'h0);
        end

        // R11: edge lines
        for (int k = 16; k < N; k++) begin
            irq_in = 32'h1 << k;
            idle(4);
            rd_chk($sformatf("R11 edge capture %0d", k), 8'h00, 32'h1 << k);
            wr(8'h0C, 32'h1 << k);
            idle(3);
            rd_chk($sformatf("R11 held high no recapture %0d", k), 8'h00, 32'h0);
            irq_in = '0;
            idle(4);
        end

        // R11: edge lost while capture off; R10 level caught once capture returns
        wr(8'h1C, 32'h0);
        irq_in = (32'h1 << 20) | (32'h1 << 3);
        idle(4);
        rd_chk("R11 capture off", 8'h00, 32'h0);
        wr(8'h1C, 32'h2);
        idle(3);
        rd_chk("R11 edge lost, R10 level taken", 8'h00, 32'h1 << 3);
        irq_in = '0;
        idle(4);
        irq_in = 32'h1 << 20;
        idle(4);
        rd_chk("R11 new edge after re-enable", 8'h00, (32'h1 << 20) | (32'h1 << 3));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule